// File: doc/BRIEF.md
# Harmful Prefetch Detector

This block sits beside a shared last-level cache and decides, for every prefetch that pushed a valid block out, whether that prefetch hurt. It judges a prefetch harmful when some core makes a demand reference to the evicted block before any core makes a demand reference to the block the prefetch brought in. Each prefetch fill that displaces a block opens a tracking slot. The slot holds the prefetched address and the core that issued the prefetch, plus the displaced address and the core that owned it.

Demand accesses arrive on several parallel access ports. Each valid demand access is compared against the two addresses held in every open slot. A hit on the displaced address closes the slot as harmful. The block then reports an event pair: a harmful-prefetch pulse naming the culprit core and a harmful-miss pulse naming the victim's owner core. These two may be the same core. A hit on the prefetched address closes the slot quietly, with no event.

Resolved slots wait and are reported one per cycle. The counting and throttling policy is left to downstream logic that consumes the pulses.

Top module: `harmful_pf_detector`

## Requirements
- R1: After reset the tracking table is empty and both event outputs are low; a demand access that follows reset produces no event.
- R2: A slot is opened only by a fill with `fill_valid`, `fill_is_pf` and `fill_victim_valid` all high; a demand fill or a prefetch fill with no displaced block opens nothing.
- R3: A demand access to a tracked displaced address, before any demand access to its prefetched address, makes `pfev_valid` and `missev_valid` high together in the cycle after the second rising edge following the access cycle.
- R4: A demand access to the tracked prefetched address first closes the slot with no event; a later access to its displaced address also produces no event.
- R5: `pfev_core` carries the core that issued the prefetch and `missev_core` the core that owned the displaced block, whether they are equal or different.
- R6: An access with its `acc_is_pf` bit high is never a reference and resolves no slot.
- R7: When the displaced and the prefetched addresses of one slot are both hit by demand accesses in the same cycle, the prefetch is judged harmful.
- R8: The table holds N_ENTRIES slots, filled in strict rotation with the oldest slot overwritten; an overwritten slot is dropped with no event.
- R9: Events are single-cycle pulses. Harmful resolutions from the same cycle are reported on successive cycles, lowest slot index first, and both core fields are zero when no event is shown.
- R10: A demand access in the same cycle as the fill that opens a slot is not matched against that new slot.
- R11: A slot resolves at most once; after its event, further accesses to its addresses produce nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A fill into the cache this cycle |
| fill_is_pf | input | 1 | The fill was caused by a prefetch |
| fill_core | input | CORE_W | Core that caused the fill |
| fill_addr | input | ADDR_W | Block address being filled |
| fill_victim_valid | input | 1 | A valid block was displaced by the fill |
| fill_victim_core | input | CORE_W | Core owning the displaced block |
| fill_victim_addr | input | ADDR_W | Address of the displaced block |
| acc_valid | input | N_PORTS | Per-port access valid |
| acc_is_pf | input | N_PORTS | Per-port prefetch flag (not a reference) |
| acc_core | input | N_PORTS*CORE_W | Per-port requesting core |
| acc_addr | input | N_PORTS*ADDR_W | Per-port block address |
| pfev_valid | output | 1 | Harmful-prefetch event pulse |
| pfev_core | output | CORE_W | Culprit core of the event |
| missev_valid | output | 1 | Harmful-miss event pulse |
| missev_core | output | CORE_W | Core whose block was displaced |

## Verification
The assertions assume two things about the inputs. First, a prefetch fill never names its own address as the displaced one. Second, every core ID on a fill or access port is below N_CORES. The random stimulus draws addresses from a small pool so that matches are frequent, and it picks the displaced address as a nonzero offset from the prefetched one. Core IDs are drawn modulo the core count. Directed sequences cover the same-cycle tie between the two addresses, same-cycle open and hit, rotation overflow, and queued reporting.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

   typedef enum logic [1:0] {
      SLOT_IDLE   = 2'd0,
      SLOT_WATCH  = 2'd1,
      SLOT_REPORT = 2'd2
   } slot_state_e;

endpackage

// File: rtl/hpd_slot.sv
module hpd_slot
   import hpd_pkg::*;
#(
   parameter int ADDR_W  = 26,
   parameter int CORE_W  = 3,
   parameter int N_PORTS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        alloc_i,
   input  logic [ADDR_W-1:0]           pf_addr_i,
   input  logic [CORE_W-1:0]           pf_core_i,
   input  logic [ADDR_W-1:0]           vic_addr_i,
   input  logic [CORE_W-1:0]           vic_core_i,
   input  logic [N_PORTS-1:0]          acc_valid_i,
   input  logic [N_PORTS-1:0]          acc_is_pf_i,
   input  logic [N_PORTS*ADDR_W-1:0]   acc_addr_i,
   input  logic                        grant_i,
   output logic                        report_o,
   output logic [CORE_W-1:0]           pf_core_o,
   output logic [CORE_W-1:0]           vic_core_o
);

   slot_state_e        state_q, state_d;
   logic [ADDR_W-1:0]  pf_addr_q, vic_addr_q;
   logic [CORE_W-1:0]  pf_core_q, vic_core_q;
   logic               vic_hit, pf_hit;

   // Only demand references count; prefetch-flagged accesses are skipped.
   always_comb begin
      vic_hit = 1'b0;
      pf_hit  = 1'b0;
      for (int p = 0; p < N_PORTS; p++) begin
         if (acc_valid_i[p] && !acc_is_pf_i[p]) begin
            if (acc_addr_i[p*ADDR_W +: ADDR_W] == vic_addr_q) vic_hit = 1'b1;
            if (acc_addr_i[p*ADDR_W +: ADDR_W] == pf_addr_q)  pf_hit  = 1'b1;
         end
      end
   end

   // Displaced-block hit is tested first, so a tie resolves as harmful.
   always_comb begin
      state_d = state_q;
      if (alloc_i) begin
         state_d = SLOT_WATCH;
      end else begin
         case (state_q)
            SLOT_WATCH: begin
               if (vic_hit)     state_d = SLOT_REPORT;
               else if (pf_hit) state_d = SLOT_IDLE;
            end
            SLOT_REPORT: begin
               if (grant_i) state_d = SLOT_IDLE;
            end
            default: state_d = SLOT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= SLOT_IDLE;
         pf_addr_q  <= '0;
         vic_addr_q <= '0;
         pf_core_q  <= '0;
         vic_core_q <= '0;
      end else begin
         state_q <= state_d;
         if (alloc_i) begin
            pf_addr_q  <= pf_addr_i;
            vic_addr_q <= vic_addr_i;
            pf_core_q  <= pf_core_i;
            vic_core_q <= vic_core_i;
         end
      end
   end

   assign report_o   = (state_q == SLOT_REPORT);
   assign pf_core_o  = pf_core_q;
   assign vic_core_o = vic_core_q;

   AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |=> (state_q == SLOT_WATCH) && (vic_addr_q == $past(vic_addr_i))); // R2
   AST_SLOT_HARMFUL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_WATCH && vic_hit && !alloc_i) |=> report_o); // R3
   AST_SLOT_TIE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_WATCH && vic_hit && pf_hit && !alloc_i) |=> report_o); // R7
   AST_SLOT_BENIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_WATCH && !vic_hit && pf_hit && !alloc_i) |=> (state_q == SLOT_IDLE)); // R4
   AST_SLOT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (report_o && grant_i && !alloc_i) |=> (state_q == SLOT_IDLE)); // R11
   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (report_o && !grant_i && !alloc_i) |=> report_o); // R9

endmodule

// File: rtl/hpd_alloc_ring.sv
module hpd_alloc_ring #(
   parameter int N_ENTRIES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push_i,
   output logic [N_ENTRIES-1:0]  slot_sel_o
);

   localparam int PTR_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

   logic [PTR_W-1:0] ptr_q, ptr_next;

   generate
      if ((N_ENTRIES & (N_ENTRIES - 1)) == 0) begin : g_pow2_wrap
         assign ptr_next = ptr_q + 1'b1;
      end else begin : g_cmp_wrap
         assign ptr_next = (ptr_q == PTR_W'(N_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr_q <= '0;
      else if (push_i) ptr_q <= ptr_next;
   end

   always_comb begin
      for (int i = 0; i < N_ENTRIES; i++) begin
         slot_sel_o[i] = push_i && (ptr_q == PTR_W'(i));
      end
   end

   AST_ALLOC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> $onehot(slot_sel_o)); // R8
   AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> !$stable(ptr_q)); // R8
   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !push_i |=> $stable(ptr_q)); // R8
   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PTR_W'(N_ENTRIES - 1)); // R8

endmodule

// File: rtl/hpd_pick.sv
module hpd_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);

   always_comb begin
      logic taken;
      taken   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && !taken) begin
            grant_o[i] = 1'b1;
            taken      = 1'b1;
         end
      end
   end

endmodule

// File: rtl/harmful_pf_detector.sv
module harmful_pf_detector
   import hpd_pkg::*;
#(
   parameter int  ADDR_W    = 26,
   parameter int  N_CORES   = 6,
   parameter int  N_ENTRIES = 8,
   parameter int  N_PORTS   = 2,
   localparam int CORE_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fill_valid,
   input  logic                       fill_is_pf,
   input  logic [CORE_W-1:0]          fill_core,
   input  logic [ADDR_W-1:0]          fill_addr,
   input  logic                       fill_victim_valid,
   input  logic [CORE_W-1:0]          fill_victim_core,
   input  logic [ADDR_W-1:0]          fill_victim_addr,
   input  logic [N_PORTS-1:0]         acc_valid,
   input  logic [N_PORTS-1:0]         acc_is_pf,
   input  logic [N_PORTS*CORE_W-1:0]  acc_core,
   input  logic [N_PORTS*ADDR_W-1:0]  acc_addr,
   output logic                       pfev_valid,
   output logic [CORE_W-1:0]          pfev_core,
   output logic                       missev_valid,
   output logic [CORE_W-1:0]          missev_core
);

   generate
      if (ADDR_W < 1)    begin : g_bad_addr  $error("ADDR_W must be at least 1");    end
      if (N_CORES < 2)   begin : g_bad_cores $error("N_CORES must be at least 2");   end
      if (N_ENTRIES < 2) begin : g_bad_depth $error("N_ENTRIES must be at least 2"); end
      if (N_PORTS < 1)   begin : g_bad_ports $error("N_PORTS must be at least 1");   end
   endgenerate

   logic                  do_alloc;
   logic [N_ENTRIES-1:0]  alloc_vec, report_vec, grant_vec;
   logic [CORE_W-1:0]     slot_pf_core  [N_ENTRIES];
   logic [CORE_W-1:0]     slot_vic_core [N_ENTRIES];
   logic [CORE_W-1:0]     sel_pf_core, sel_vic_core;
   logic                  evt_q;
   logic [CORE_W-1:0]     evt_pf_core_q, evt_vic_core_q;

   assign do_alloc = fill_valid && fill_is_pf && fill_victim_valid;

   hpd_alloc_ring #(
      .N_ENTRIES (N_ENTRIES)
   ) i_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (do_alloc),
      .slot_sel_o (alloc_vec)
   );

   generate
      for (genvar s = 0; s < N_ENTRIES; s++) begin : g_slot
         hpd_slot #(
            .ADDR_W  (ADDR_W),
            .CORE_W  (CORE_W),
            .N_PORTS (N_PORTS)
         ) i_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (alloc_vec[s]),
            .pf_addr_i   (fill_addr),
            .pf_core_i   (fill_core),
            .vic_addr_i  (fill_victim_addr),
            .vic_core_i  (fill_victim_core),
            .acc_valid_i (acc_valid),
            .acc_is_pf_i (acc_is_pf),
            .acc_addr_i  (acc_addr),
            .grant_i     (grant_vec[s]),
            .report_o    (report_vec[s]),
            .pf_core_o   (slot_pf_core[s]),
            .vic_core_o  (slot_vic_core[s])
         );
      end
   endgenerate

   hpd_pick #(
      .N (N_ENTRIES)
   ) i_pick (
      .req_i   (report_vec),
      .grant_o (grant_vec)
   );

   always_comb begin
      sel_pf_core  = '0;
      sel_vic_core = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (grant_vec[i]) begin
            sel_pf_core  = sel_pf_core  | slot_pf_core[i];
            sel_vic_core = sel_vic_core | slot_vic_core[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q          <= 1'b0;
         evt_pf_core_q  <= '0;
         evt_vic_core_q <= '0;
      end else begin
         evt_q          <= |report_vec;
         evt_pf_core_q  <= sel_pf_core;
         evt_vic_core_q <= sel_vic_core;
      end
   end

   assign pfev_valid   = evt_q;
   assign missev_valid = evt_q;
   assign pfev_core    = evt_pf_core_q;
   assign missev_core  = evt_vic_core_q;

   AST_FILL_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      do_alloc |-> (fill_addr != fill_victim_addr)); // R2
   AST_FILL_CORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      do_alloc |-> (fill_core < CORE_W'(N_CORES - 1) + 1'b1 || fill_core == CORE_W'(N_CORES - 1))
                   && (fill_victim_core <= CORE_W'(N_CORES - 1))); // R5
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec)); // R9
   AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vec & ~report_vec) == '0); // R9
   AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|report_vec) |-> (|grant_vec)); // R9
   AST_EVT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pfev_valid) |-> $past(|report_vec)); // R3
   AST_EVT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !pfev_valid |-> (pfev_core == '0 && missev_core == '0)); // R9

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_port_chk
         AST_ACC_CORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid[p] |-> (acc_core[p*CORE_W +: CORE_W] <= CORE_W'(N_CORES - 1))); // R5
      end
   endgenerate

endmodule

// File: tb/test_harmful_pf_detector.sv
module test_harmful_pf_detector;

   localparam int AW = 26;
   localparam int NC = 6;
   localparam int NE = 8;
   localparam int NP = 2;
   localparam int CW = 3;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                fill_valid, fill_is_pf, fill_victim_valid;
   logic [CW-1:0]       fill_core, fill_victim_core;
   logic [AW-1:0]       fill_addr, fill_victim_addr;
   logic [NP-1:0]       acc_valid, acc_is_pf;
   logic [NP*CW-1:0]    acc_core;
   logic [NP*AW-1:0]    acc_addr;
   logic                pfev_valid, missev_valid;
   logic [CW-1:0]       pfev_core, missev_core;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   // reference model state
   int  m_state [NE];
   int  m_pfa [NE];
   int  m_via [NE];
   int  m_pfc [NE];
   int  m_vic [NE];
   int  m_ptr;
   int  m_evt, m_epc, m_evc;

   always #10ns clk = ~clk;

   harmful_pf_detector #(
      .ADDR_W    (AW),
      .N_CORES   (NC),
      .N_ENTRIES (NE),
      .N_PORTS   (NP)
   ) i_harmful_pf_detector (
      .clk               (clk),
      .rst_n             (rst_n),
      .fill_valid        (fill_valid),
      .fill_is_pf        (fill_is_pf),
      .fill_core         (fill_core),
      .fill_addr         (fill_addr),
      .fill_victim_valid (fill_victim_valid),
      .fill_victim_core  (fill_victim_core),
      .fill_victim_addr  (fill_victim_addr),
      .acc_valid         (acc_valid),
      .acc_is_pf         (acc_is_pf),
      .acc_core          (acc_core),
      .acc_addr          (acc_addr),
      .pfev_valid        (pfev_valid),
      .pfev_core         (pfev_core),
      .missev_valid      (missev_valid),
      .missev_core       (missev_core)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NE; i++) begin
         m_state[i] = 0; m_pfa[i] = 0; m_via[i] = 0; m_pfc[i] = 0; m_vic[i] = 0;
      end
      m_ptr = 0; m_evt = 0; m_epc = 0; m_evc = 0;
   endtask

   // One clock: advance the model from the present inputs, then sample at negedge.
   task automatic cyc(input string tag);
      int g;
      g = -1;
      for (int i = 0; i < NE; i++) if (m_state[i] == 2 && g < 0) g = i;
      m_evt = (g >= 0) ? 1 : 0;
      m_epc = (g >= 0) ? m_pfc[g] : 0;
      m_evc = (g >= 0) ? m_vic[g] : 0;
      for (int i = 0; i < NE; i++) begin
         bit vh, ph;
         vh = 1'b0; ph = 1'b0;
         for (int p = 0; p < NP; p++) begin
            if (acc_valid[p] && !acc_is_pf[p]) begin
               if (int'(acc_addr[p*AW +: AW]) == m_via[i]) vh = 1'b1;
               if (int'(acc_addr[p*AW +: AW]) == m_pfa[i]) ph = 1'b1;
            end
         end
         if (i == g) m_state[i] = 0;
         else if (m_state[i] == 1 && vh) m_state[i] = 2;
         else if (m_state[i] == 1 && ph) m_state[i] = 0;
      end
      if (fill_valid && fill_is_pf && fill_victim_valid) begin
         m_state[m_ptr] = 1;
         m_pfa[m_ptr] = int'(fill_addr);
         m_via[m_ptr] = int'(fill_victim_addr);
         m_pfc[m_ptr] = int'(fill_core);
         m_vic[m_ptr] = int'(fill_victim_core);
         m_ptr = (m_ptr + 1) % NE;
      end
      @(negedge clk);
      check({tag, " pfev_valid"},   int'(pfev_valid),   m_evt);
      check({tag, " missev_valid"}, int'(missev_valid), m_evt);
      check({tag, " pfev_core"},    int'(pfev_core),    m_epc);
      check({tag, " missev_core"},  int'(missev_core),  m_evc);
   endtask

   task automatic drive_idle();
      fill_valid = 1'b0; fill_is_pf = 1'b0; fill_victim_valid = 1'b0;
      fill_core = '0; fill_victim_core = '0; fill_addr = '0; fill_victim_addr = '0;
      acc_valid = '0; acc_is_pf = '0; acc_core = '0; acc_addr = '0;
   endtask

   task automatic do_reset();
      drive_idle();
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_fill(input int c, input int a, input int vc, input int va, input string tag);
      drive_idle();
      fill_valid = 1'b1; fill_is_pf = 1'b1; fill_victim_valid = 1'b1;
      fill_core = CW'(c); fill_addr = AW'(a);
      fill_victim_core = CW'(vc); fill_victim_addr = AW'(va);
      cyc(tag);
   endtask

   task automatic do_demand(input int a, input string tag);
      drive_idle();
      acc_valid[0] = 1'b1;
      acc_core[0 +: CW] = CW'(1);
      acc_addr[0 +: AW] = AW'(a);
      cyc(tag);
   endtask

   task automatic do_idle(input string tag);
      drive_idle();
      cyc(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(1234));
      do_reset();

      // R1: reset state and an access into an empty table
      check("R1 pfev_valid", int'(pfev_valid), 0);
      check("R1 missev_valid", int'(missev_valid), 0);
      do_demand('h200, "R1");
      do_idle("R1");
      check("R1 no event", int'(pfev_valid), 0);

      // R3 / R5: different cores
      do_fill(2, 'h100, 4, 'h200, "R2");
      do_demand('h200, "R3");
      check("R3 early", int'(pfev_valid), 0);
      do_idle("R3");
      check("R3 valid", int'(pfev_valid), 1);
      check("R3 miss valid", int'(missev_valid), 1);
      check("R5 culprit", int'(pfev_core), 2);
      check("R5 victim", int'(missev_core), 4);
      do_idle("R9");
      check("R9 single pulse", int'(pfev_valid), 0);

      // R11: resolved slot stays closed
      do_demand('h200, "R11");
      do_idle("R11");
      check("R11 no repeat", int'(pfev_valid), 0);

      // R5: same core on both sides
      do_fill(3, 'h110, 3, 'h210, "R5");
      do_demand('h210, "R5");
      do_idle("R5");
      check("R5 same culprit", int'(pfev_core), 3);
      check("R5 same victim", int'(missev_core), 3);

      // R4: benign
      do_fill(1, 'h120, 0, 'h220, "R4");
      do_demand('h120, "R4");
      do_idle("R4");
      check("R4 no event", int'(pfev_valid), 0);
      do_demand('h220, "R4");
      do_idle("R4");
      check("R4 late victim", int'(pfev_valid), 0);

      // R6: prefetch-flagged access is ignored
      do_fill(5, 'h130, 2, 'h230, "R6");
      drive_idle();
      acc_valid[0] = 1'b1; acc_is_pf[0] = 1'b1; acc_addr[0 +: AW] = AW'('h230);
      cyc("R6");
      do_idle("R6");
      check("R6 ignored", int'(pfev_valid), 0);
      do_demand('h230, "R6");
      do_idle("R6");
      check("R6 still open", int'(pfev_valid), 1);
      check("R6 culprit", int'(pfev_core), 5);

      // R7: tie between both addresses
      do_fill(4, 'h140, 1, 'h240, "R7");
      drive_idle();
      acc_valid = 2'b11;
      acc_addr[0 +: AW]  = AW'('h140);
      acc_addr[AW +: AW] = AW'('h240);
      cyc("R7");
      do_idle("R7");
      check("R7 harmful", int'(pfev_valid), 1);
      check("R7 victim", int'(missev_core), 1);

      // R2: fills that must not open a slot
      drive_idle();
      fill_valid = 1'b1; fill_is_pf = 1'b0; fill_victim_valid = 1'b1;
      fill_addr = AW'('h150); fill_victim_addr = AW'('h250);
      cyc("R2");
      drive_idle();
      fill_valid = 1'b1; fill_is_pf = 1'b1; fill_victim_valid = 1'b0;
      fill_addr = AW'('h151); fill_victim_addr = AW'('h251);
      cyc("R2");
      do_demand('h250, "R2");
      do_demand('h251, "R2");
      do_idle("R2");
      check("R2 no slot", int'(pfev_valid), 0);
      do_idle("R2");
      check("R2 no slot later", int'(pfev_valid), 0);

      // R10: same-cycle fill and hit
      drive_idle();
      fill_valid = 1'b1; fill_is_pf = 1'b1; fill_victim_valid = 1'b1;
      fill_core = CW'(2); fill_addr = AW'('h160);
      fill_victim_core = CW'(5); fill_victim_addr = AW'('h260);
      acc_valid[0] = 1'b1; acc_addr[0 +: AW] = AW'('h260);
      cyc("R10");
      do_idle("R10");
      check("R10 not matched", int'(pfev_valid), 0);
      do_demand('h260, "R10");
      do_idle("R10");
      check("R10 later hit", int'(pfev_valid), 1);
      check("R10 victim", int'(missev_core), 5);

      // R8: rotation overwrites the oldest slot
      do_reset();
      for (int i = 0; i < NE + 1; i++) do_fill(i % NC, 'h300 + i, (i + 1) % NC, 'h400 + i, "R8");
      do_demand('h400, "R8");
      do_idle("R8");
      check("R8 dropped", int'(pfev_valid), 0);
      do_demand('h401, "R8");
      do_idle("R8");
      check("R8 kept", int'(pfev_valid), 1);
      check("R8 culprit", int'(pfev_core), 1);

      // R9: two resolutions in one cycle, lowest slot first
      do_reset();
      do_fill(1, 'h500, 5, 'h600, "R9");
      do_fill(2, 'h501, 0, 'h601, "R9");
      drive_idle();
      acc_valid = 2'b11;
      acc_addr[0 +: AW]  = AW'('h601);
      acc_addr[AW +: AW] = AW'('h600);
      cyc("R9");
      do_idle("R9");
      check("R9 first culprit", int'(pfev_core), 1);
      check("R9 first victim", int'(missev_core), 5);
      do_idle("R9");
      check("R9 second culprit", int'(pfev_core), 2);
      check("R9 second victim", int'(missev_core), 0);
      do_idle("R9");
      check("R9 drained", int'(pfev_valid), 0);

      // constrained random traffic against the model
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         drive_idle();
         if ($urandom % 3 == 0) begin
            int a;
            a = $urandom % 16;
            fill_valid = 1'b1;
            fill_is_pf = ($urandom % 4 != 0);
            fill_victim_valid = ($urandom % 5 != 0);
            fill_core = CW'($urandom % NC);
            fill_victim_core = CW'($urandom % NC);
            fill_addr = AW'(a);
            fill_victim_addr = AW'((a + 1 + ($urandom % 15)) % 16);
         end
         for (int p = 0; p < NP; p++) begin
            acc_valid[p] = ($urandom % 2 == 0);
            acc_is_pf[p] = ($urandom % 4 == 0);
            acc_core[p*CW +: CW] = CW'($urandom % NC);
            acc_addr[p*AW +: AW] = AW'($urandom % 16);
         end
         cyc("R3 random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule